// File: doc/BRIEF.md
# Expansion Register Window with Multiplier

This block is a small register window that a CPU reaches through the low expansion part of its address map. It holds a 2-bit count of system reset events, an unsigned multiplier that takes two byte operands and gives a 16-bit product, and a single byte of scratch storage. Only some address bits take part in the decode, so every register appears at many aliases across the window.

The CPU writes operands and scratch data with a write strobe, and the block captures them on the clock edge. Reads are combinational. While the read strobe is high and the address hits a decoded register, the block raises a drive-enable and presents the byte. A separate reset-event input advances the counter. That input leaves every other piece of state alone. Only the power-on reset clears the counter.

Top module: `xreg_window`

## Requirements
- R1: After power-on reset (`rst_n` low), the reset counter, both operands and the scratch byte are all zero, so reads of the status, product and scratch registers return 0x00.
- R2: Each clock cycle with `reset_evt` high adds one to the 2-bit reset counter, which wraps from 3 to 0. A read of the status register returns the count in bits 1:0 and zeros in bits 7:2.
- R3: `reset_evt` leaves the operands and the scratch byte unchanged.
- R4: Writes to the status register are ignored and leave the count unchanged.
- R5: A write to the operand-A register (key 0x5800) loads operand A. A write to the operand-B register (key 0x5801) loads operand B.
- R6: A read at key 0x5800 returns bits 7:0 of the unsigned product A×B, and a read at key 0x5801 returns bits 15:8. The product follows new operands in the cycle after the write.
- R7: A write to the scratch register (key 0x5803) stores the byte, and later reads at that key return it.
- R8: The decode key is the address ANDed with 0xF803. Any address whose key equals 0x5000 (status), 0x5800, 0x5801 or 0x5803 reaches that register.
- R9: `drive_en` is high exactly when `rd` is high and the key matches one of the four decoded values. When `drive_en` is low, `rdata` is 0x00.
- R10: Writes to addresses whose key matches no register that software can write (for example 0x5802, 0x5001 or 0x6000) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears all state |
| reset_evt | input | 1 | One-cycle pulse per system reset event |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| rdata | output | 8 | Read data, 0x00 when not driving |
| drive_en | output | 1 | High when the block should drive the data bus |

## Verification
A wrong operand register shows up as a wrong product byte at the next read, one cycle after the faulty write. A wrong reset count shows on the next status read after a `reset_evt` pulse. A mistake in the decode is the hardest fault to see, because it touches only some aliases. It appears at the ports as `drive_en` rising for an address that should stay silent, or staying low for an alias that should answer. For that reason the bench reads every one of the 65,536 addresses with the state preset to known values. The multiplier is swept over every value of operand A against sixteen spread values of operand B.

// File: rtl/xreg_window.sv
module xreg_window #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 2,
  parameter logic [AW-1:0] DEC_MASK = 16'hF803,
  parameter logic [AW-1:0] STAT_KEY = 16'h5000,
  parameter logic [AW-1:0] LO_KEY   = 16'h5800,
  parameter logic [AW-1:0] HI_KEY   = 16'h5801,
  parameter logic [AW-1:0] RAM_KEY  = 16'h5803
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_evt,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);
  localparam int PW = 2 * DW;

  logic [CW-1:0] cnt;
  logic [DW-1:0] op_a, op_b, ram;
  logic [PW-1:0] prod;
  logic [AW-1:0] key;
  logic          hit_stat, hit_lo, hit_hi, hit_ram;
  logic [DW-1:0] sel;

  assign key      = addr & DEC_MASK;
  assign hit_stat = (key == STAT_KEY);
  assign hit_lo   = (key == LO_KEY);
  assign hit_hi   = (key == HI_KEY);
  assign hit_ram  = (key == RAM_KEY);

  assign prod = PW'(op_a) * PW'(op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      op_a <= '0;
      op_b <= '0;
      ram  <= '0;
    end else begin
      if (reset_evt)       cnt  <= cnt + 1'b1;
      if (wr && hit_lo)    op_a <= wdata;
      if (wr && hit_hi)    op_b <= wdata;
      if (wr && hit_ram)   ram  <= wdata;
    end
  end

  always_comb begin
    sel = '0;
    unique case (1'b1)
      hit_stat: sel = DW'(cnt);
      hit_lo:   sel = prod[DW-1:0];
      hit_hi:   sel = prod[PW-1:DW];
      hit_ram:  sel = ram;
      default:  sel = '0;
    endcase
  end

  assign drive_en = rd & (hit_stat | hit_lo | hit_hi | hit_ram);
  assign rdata    = drive_en ? sel : '0;
endmodule

module xreg_window_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 2,
  parameter logic [AW-1:0] DEC_MASK = 16'hF803,
  parameter logic [AW-1:0] STAT_KEY = 16'h5000,
  parameter logic [AW-1:0] RAM_KEY  = 16'h5803
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reset_evt,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] rdata,
  input logic          drive_en,
  input logic [CW-1:0] cnt,
  input logic [DW-1:0] ram
);
  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (rdata == '0));
  // R9
  drive_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !drive_en);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> (cnt == CW'($past(cnt) + 1'b1)));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_evt |=> $stable(cnt));
  // R7
  ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ((addr & DEC_MASK) == RAM_KEY)) |=> (ram == $past(wdata)));
  // R3
  ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && ((addr & DEC_MASK) == RAM_KEY)) |=> $stable(ram));
  // R2
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ((addr & DEC_MASK) == STAT_KEY)) |-> (drive_en && rdata == DW'(cnt)));
endmodule

bind xreg_window xreg_window_chk #(
  .AW(AW), .DW(DW), .CW(CW), .DEC_MASK(DEC_MASK),
  .STAT_KEY(STAT_KEY), .RAM_KEY(RAM_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .addr(addr),
  .wdata(wdata), .rd(rd), .wr(wr), .rdata(rdata), .drive_en(drive_en),
  .cnt(cnt), .ram(ram)
);

// File: tb/sim_xreg_window.sv
module sim_xreg_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_evt = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  logic        drive_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xreg_window u0 (.clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .addr(addr),
    .wdata(wdata), .rd(rd), .wr(wr), .rdata(rdata), .drive_en(drive_en));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, output int v, output int en);
    rd = 1'b1; addr = a;
    #1;
    v = int'(rdata); en = int'(drive_en);
    rd = 1'b0;
    #1;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    reset_evt = 1'b1;
    @(negedge clk);
    reset_evt = 1'b0;
    exp_cnt = (exp_cnt + 1) % 4;
  endtask

  function automatic int key_kind(logic [15:0] a);
    logic [15:0] k;
    k = a & 16'hF803;
    if (k == 16'h5000) return 1;
    if (k == 16'h5800) return 2;
    if (k == 16'h5801) return 3;
    if (k == 16'h5803) return 4;
    return 0;
  endfunction

  initial begin
    int v, en, p, opa, opb, ramv, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_rd(16'h5000, v, en); check("R1 status", v, 0);
    bus_rd(16'h5800, v, en); check("R1 prod lo", v, 0);
    bus_rd(16'h5801, v, en); check("R1 prod hi", v, 0);
    bus_rd(16'h5803, v, en); check("R1 ram", v, 0);

    // R5 R6: multiplier sweep
    for (int a = 0; a < 256; a++) begin
      bus_wr(16'h5800, 8'(a));
      for (int b = 0; b < 256; b += 17) begin
        bus_wr(16'h5801, 8'(b));
        p = a * b;
        bus_rd(16'h5800, v, en); check("R6 prod lo", v, p & 255);
        bus_rd(16'h5801, v, en); check("R6 prod hi", v, p >> 8);
      end
    end

    // R7: scratch byte
    bus_wr(16'h5803, 8'hA5);
    bus_rd(16'h5803, v, en); check("R7 ram", v, 8'hA5);
    bus_wr(16'hFFFF, 8'h5A);
    bus_rd(16'h5803, v, en); check("R7 ram alias write", v, 8'hA5);
    bus_wr(16'h5FFB, 8'h3C);
    bus_rd(16'h5807, v, en); check("R7 ram alias", v, 8'h3C);

    // R2 R3: reset events advance count, keep operands and ram
    bus_wr(16'h5800, 8'hC3);
    bus_wr(16'h5801, 8'h5A);
    for (int i = 0; i < 6; i++) begin
      pulse_evt();
      bus_rd(16'h5000, v, en); check("R2 count", v, exp_cnt);
    end
    bus_rd(16'h5803, v, en); check("R3 ram kept", v, 8'h3C);
    bus_rd(16'h5800, v, en); check("R3 prod lo kept", v, (195*90) & 255);
    bus_rd(16'h5801, v, en); check("R3 prod hi kept", v, (195*90) >> 8);

    // R4: writes to status ignored
    bus_wr(16'h5000, 8'hFF);
    bus_wr(16'h5004, 8'hFE);
    bus_rd(16'h5000, v, en); check("R4 status kept", v, exp_cnt);

    // R10: writes to undecoded addresses
    bus_wr(16'h5802, 8'h11);
    bus_wr(16'h5001, 8'h22);
    bus_wr(16'h6000, 8'h33);
    bus_wr(16'h4800, 8'h44);
    bus_rd(16'h5803, v, en); check("R10 ram", v, 8'h3C);
    bus_rd(16'h5800, v, en); check("R10 prod lo", v, (195*90) & 255);
    bus_rd(16'h5801, v, en); check("R10 prod hi", v, (195*90) >> 8);
    bus_rd(16'h5000, v, en); check("R10 status", v, exp_cnt);

    // R8 R9: full address sweep
    opa = 195; opb = 90; ramv = 8'h3C;
    for (int ad = 0; ad < 65536; ad++) begin
      int kind;
      kind = key_kind(16'(ad));
      bus_rd(16'(ad), v, en);
      case (kind)
        1: exp = exp_cnt;
        2: exp = (opa * opb) & 255;
        3: exp = (opa * opb) >> 8;
        4: exp = ramv;
        default: exp = 0;
      endcase
      if (en != (kind != 0 ? 1 : 0)) check("R9 drive_en", en, kind != 0 ? 1 : 0);
      else if (v != exp) check("R8 data", v, exp);
      else n_chk++;
    end
    addr = 16'h5800; #1;
    check("R9 no rd no drive", int'(drive_en), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule